// File: doc/BRIEF.md
# Cascadable Bit-Sliced Arithmetic-Logic Unit

This block is a word-wide arithmetic-logic unit built by repeating one 4-bit slice. The word width is a parameter and must be a non-zero multiple of four. Each slice works on its own 4-bit field of the two operands. A single 3-bit operation code goes to every slice in parallel, so all slices perform the same operation in the same instant.

The carry enters the least significant slice from the external carry input. Inside each slice it ripples from bit 0 to bit 3, and then from each slice into the next. The carry leaving the top slice is the block's carry output. The unit is purely combinational: the result follows any change on the operands, the carry input or the operation code. It holds no state.

Top module: `sliced_alu`

## Requirements
- R1: Operation code 0 (add) gives {carry_o, result_o} = opa_i + opb_i + carry_i, taken over the full word.
- R2: Operation code 1 (add inverted) gives {carry_o, result_o} = opa_i + ~opb_i + carry_i. With carry_i = 1 the result is opa_i - opb_i, and carry_o = 1 exactly when opa_i >= opb_i.
- R3: Operation code 2 gives result_o = opa_i & opb_i.
- R4: Operation code 3 gives result_o = opa_i & ~opb_i.
- R5: Operation code 4 gives result_o = opa_i | opb_i.
- R6: Operation code 5 gives result_o = opa_i | ~opb_i.
- R7: Operation code 6 passes opb_i to result_o, and operation code 7 passes opa_i to result_o.
- R8: For operation codes 2 through 7, carry_o is 0 and no carry passes between slices, whatever carry_i is.
- R9: For operation codes 2 through 7, carry_i has no effect on result_o.
- R10: The carry out of slice k is the carry in of slice k+1. A carry raised in bit 0 therefore reaches carry_o through every slice: all-ones plus one gives a zero result with carry_o = 1.
- R11: The width parameter accepts any non-zero multiple of four. Each width behaves as the whole-word arithmetic of R1 to R8 at that width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | WIDTH | Operand A |
| opb_i | input | WIDTH | Operand B |
| carry_i | input | 1 | Carry into the least significant slice |
| op_i | input | 3 | Operation code, shared by all slices |
| result_o | output | WIDTH | Result word |
| carry_o | output | 1 | Carry out of the most significant slice |

## Verification
The bench builds two copies of the unit, one with WIDTH = 8 and one with WIDTH = 16. The 8-bit copy has two slices, which makes a complete sweep of both operands, the carry input and all eight operation codes affordable. Every slice-to-slice carry case is therefore reached there. The 16-bit copy has four slices and a carry path through all of them. It runs a table of corner vectors: full ripple, subtraction with and without borrow, and logic operations with carry_i set. After the table it runs random operands compared against a whole-word model.

// File: rtl/sliced_alu_pkg.sv
package sliced_alu_pkg;

  localparam int unsigned SLICE_W = 4;
  localparam int unsigned OP_W    = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD    = 3'd0,
    OP_ADD_NB = 3'd1,
    OP_AND    = 3'd2,
    OP_ANDN   = 3'd3,
    OP_OR     = 3'd4,
    OP_ORN    = 3'd5,
    OP_PASS_B = 3'd6,
    OP_PASS_A = 3'd7
  } alu_op_e;

  // True when the operation uses the carry chain.
  function automatic logic is_arith(input alu_op_e op);
    return (op == OP_ADD) || (op == OP_ADD_NB);
  endfunction

  // One-bit evaluation: returns {carry_out, result_bit}.
  function automatic logic [1:0] bit_eval(input logic a, input logic b,
                                          input logic ci, input alu_op_e op);
    logic bx;
    logic y;
    logic co;
    bx = (op == OP_ADD_NB) ? ~b : b;
    y  = 1'b0;
    co = 1'b0;
    unique case (op)
      OP_ADD, OP_ADD_NB: begin
        y  = a ^ bx ^ ci;
        co = (a & bx) | (a & ci) | (bx & ci);
      end
      OP_AND:    y = a & b;
      OP_ANDN:   y = a & ~b;
      OP_OR:     y = a | b;
      OP_ORN:    y = a | ~b;
      OP_PASS_B: y = b;
      OP_PASS_A: y = a;
      default:   y = 1'b0;
    endcase
    return {co, y};
  endfunction

endpackage

// File: rtl/sliced_alu_bit.sv
module sliced_alu_bit
  import sliced_alu_pkg::*;
(
  input  logic    a_i,
  input  logic    b_i,
  input  logic    c_i,
  input  alu_op_e op_i,
  output logic    y_o,
  output logic    c_o
);

  logic [1:0] eval;

  always_comb begin
    eval = bit_eval(a_i, b_i, c_i, op_i);
  end

  assign y_o = eval[0];
  assign c_o = eval[1];

endmodule

// File: rtl/sliced_alu_slice.sv
module sliced_alu_slice
  import sliced_alu_pkg::*;
(
  input  logic [SLICE_W-1:0] a_i,
  input  logic [SLICE_W-1:0] b_i,
  input  logic               c_i,
  input  alu_op_e            op_i,
  output logic [SLICE_W-1:0] y_o,
  output logic               c_o
);

  // Bit-level carry chain: bit_carry[0] enters bit 0, bit_carry[SLICE_W] leaves.
  logic [SLICE_W:0] bit_carry;

  assign bit_carry[0] = c_i;

  for (genvar i = 0; i < SLICE_W; i++) begin : g_bit
    sliced_alu_bit u_bit (
      .a_i  (a_i[i]),
      .b_i  (b_i[i]),
      .c_i  (bit_carry[i]),
      .op_i (op_i),
      .y_o  (y_o[i]),
      .c_o  (bit_carry[i+1])
    );
  end

  assign c_o = bit_carry[SLICE_W];

endmodule

// File: rtl/sliced_alu.sv
module sliced_alu
  import sliced_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic             carry_i,
  input  logic [2:0]       op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o
);

  localparam int unsigned NSLICE = WIDTH / SLICE_W;

  if ((WIDTH % SLICE_W) != 0 || WIDTH == 0) begin : g_bad_width
    $error("sliced_alu: WIDTH must be a non-zero multiple of the slice width");
  end

  alu_op_e op_sel;
  assign op_sel = alu_op_e'(op_i);

  // Slice-level carry chain, brought out for the checker.
  logic [NSLICE:0] slice_carry;

  assign slice_carry[0] = carry_i;

  for (genvar k = 0; k < NSLICE; k++) begin : g_slice
    sliced_alu_slice u_slice (
      .a_i  (opa_i[k*SLICE_W +: SLICE_W]),
      .b_i  (opb_i[k*SLICE_W +: SLICE_W]),
      .c_i  (slice_carry[k]),
      .op_i (op_sel),
      .y_o  (result_o[k*SLICE_W +: SLICE_W]),
      .c_o  (slice_carry[k+1])
    );
  end

  assign carry_o = slice_carry[NSLICE];

endmodule

// File: rtl/sliced_alu_chk.sv
module sliced_alu_chk #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned NSLICE = WIDTH / 4
) (
  input logic [WIDTH-1:0] opa_i,
  input logic [WIDTH-1:0] opb_i,
  input logic             carry_i,
  input logic [2:0]       op_i,
  input logic [WIDTH-1:0] result_o,
  input logic             carry_o,
  input logic [NSLICE:0]  slice_carry
);

  logic             known;
  logic             arith;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   word_sum;

  always_comb begin
    known    = !$isunknown({opa_i, opb_i, carry_i, op_i});
    arith    = (op_i == 3'd0) || (op_i == 3'd1);
    b_eff    = (op_i == 3'd1) ? ~opb_i : opb_i;
    word_sum = {1'b0, opa_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, carry_i};
  end

  always_comb begin
    if (known) begin
      if (op_i == 3'd0)
        p_add_word_r1: assert ({carry_o, result_o} == word_sum)
          else $error("R1 add mismatch");
      if (op_i == 3'd1)
        p_addnb_word_r2: assert ({carry_o, result_o} == word_sum)
          else $error("R2 add-inverted mismatch");
      if (op_i == 3'd2)
        p_and_r3: assert (result_o == (opa_i & opb_i)) else $error("R3 AND mismatch");
      if (op_i == 3'd3)
        p_andn_r4: assert (result_o == (opa_i & ~opb_i)) else $error("R4 ANDN mismatch");
      if (op_i == 3'd4)
        p_or_r5: assert (result_o == (opa_i | opb_i)) else $error("R5 OR mismatch");
      if (op_i == 3'd5)
        p_orn_r6: assert (result_o == (opa_i | ~opb_i)) else $error("R6 ORN mismatch");
      if (op_i == 3'd6)
        p_pass_b_r7: assert (result_o == opb_i) else $error("R7 pass B mismatch");
      if (op_i == 3'd7)
        p_pass_a_r7: assert (result_o == opa_i) else $error("R7 pass A mismatch");
      if (!arith)
        p_no_carry_r8: assert (slice_carry[NSLICE:1] == '0 && carry_o == 1'b0)
          else $error("R8 carry seen on a logic operation");
    end
  end

  // Each slice boundary carry equals the carry out of the low-order partial sum.
  for (genvar k = 1; k <= NSLICE; k++) begin : g_boundary
    localparam int unsigned LW = 4 * k;
    logic [LW:0] part_sum;
    always_comb begin
      part_sum = {1'b0, opa_i[LW-1:0]} + {1'b0, b_eff[LW-1:0]} + {{LW{1'b0}}, carry_i};
      if (known && arith)
        p_slice_carry_r10: assert (slice_carry[k] == part_sum[LW])
          else $error("R10 slice carry mismatch at boundary %0d", k);
    end
  end

endmodule

bind sliced_alu sliced_alu_chk #(.WIDTH(WIDTH), .NSLICE(NSLICE)) u_sliced_alu_chk (
  .opa_i       (opa_i),
  .opb_i       (opb_i),
  .carry_i     (carry_i),
  .op_i        (op_i),
  .result_o    (result_o),
  .carry_o     (carry_o),
  .slice_carry (slice_carry)
);

// File: tb/test_sliced_alu.sv
module test_sliced_alu;

  localparam int W16 = 16;
  localparam int W8  = 8;
  localparam int WATCHDOG_CYCLES = 190000;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  // 16-bit copy
  logic [W16-1:0] a16, b16, y16;
  logic           ci16, co16;
  logic [2:0]     op16;

  sliced_alu #(.WIDTH(W16)) i_sliced_alu (
    .opa_i(a16), .opb_i(b16), .carry_i(ci16), .op_i(op16),
    .result_o(y16), .carry_o(co16)
  );

  // 8-bit copy
  logic [W8-1:0] a8, b8, y8;
  logic          ci8, co8;
  logic [2:0]    op8;

  sliced_alu #(.WIDTH(W8)) i_sliced_alu_w8 (
    .opa_i(a8), .opb_i(b8), .carry_i(ci8), .op_i(op8),
    .result_o(y8), .carry_o(co8)
  );

  // Whole-word reference model, returns {carry, result} in the low w+1 bits.
  function automatic logic [16:0] model(input int w, input logic [15:0] a,
                                        input logic [15:0] b, input logic ci,
                                        input logic [2:0] op);
    longint mask, s, ua, ub;
    logic [16:0] r;
    mask = (longint'(1) << w) - 1;
    ua = longint'(a) & mask;
    ub = longint'(b) & mask;
    s  = 0;
    case (op)
      3'd0: s = ua + ub + longint'(ci);
      3'd1: s = ua + ((~ub) & mask) + longint'(ci);
      3'd2: s = ua & ub;
      3'd3: s = ua & ((~ub) & mask);
      3'd4: s = ua | ub;
      3'd5: s = ua | ((~ub) & mask);
      3'd6: s = ub;
      default: s = ua;
    endcase
    r = 17'(s & ((mask << 1) | 1));
    return r;
  endfunction

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input logic [16:0] got, input logic [16:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%05h expected 0x%05h", req, got, exp);
    end
  endtask

  // Directed table for the 16-bit copy: {op, cin, a, b, exp_carry, exp_result}
  localparam int NVEC = 12;
  localparam logic [52:0] VEC [NVEC] = '{
    {3'd0, 1'b0, 16'h0001, 16'hFFFF, 1'b1, 16'h0000},  // R10 full ripple
    {3'd0, 1'b1, 16'hFFFF, 16'h0000, 1'b1, 16'h0000},  // R10 carry-in ripple
    {3'd0, 1'b0, 16'h1234, 16'h4321, 1'b0, 16'h5555},  // R1
    {3'd1, 1'b1, 16'h5000, 16'h1234, 1'b1, 16'h3DCC},  // R2 no borrow
    {3'd1, 1'b1, 16'h0001, 16'h0002, 1'b0, 16'hFFFF},  // R2 borrow
    {3'd1, 1'b0, 16'h1000, 16'h0FFF, 1'b1, 16'h0000},  // R2 cin 0
    {3'd2, 1'b1, 16'hF0F0, 16'hFF00, 1'b0, 16'hF000},  // R3 R8
    {3'd3, 1'b1, 16'hF0F0, 16'hFF00, 1'b0, 16'h00F0},  // R4 R8
    {3'd4, 1'b1, 16'hF0F0, 16'h0F00, 1'b0, 16'hFFF0},  // R5 R8
    {3'd5, 1'b1, 16'hF0F0, 16'hFF00, 1'b0, 16'hF0FF},  // R6 R8
    {3'd6, 1'b1, 16'h1234, 16'hABCD, 1'b0, 16'hABCD},  // R7 pass B
    {3'd7, 1'b1, 16'h1234, 16'hABCD, 1'b0, 16'h1234}   // R7 pass A
  };

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!done && cycles >= WATCHDOG_CYCLES) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected fewer than %0d", cycles, WATCHDOG_CYCLES);
      finish_run();
    end
  end

  initial begin
    a16 = '0; b16 = '0; ci16 = 1'b0; op16 = 3'd0;
    a8  = '0; b8  = '0; ci8  = 1'b0; op8  = 3'd0;
    #5;
    // Idle state: zero inputs give zero outputs (R1)
    check("R1 idle", {co16, y16}, 17'h0);
    check("R1 idle w8", {8'h0, co8, y8}, 17'h0);

    // Directed table (R1-related corners, subtraction, logic ops)
    for (int i = 0; i < NVEC; i++) begin
      {op16, ci16, a16, b16} = VEC[i][52:17];
      #1;
      check(req_of(op16), {co16, y16}, VEC[i][16:0]);
      #1;
    end

    // R9: carry_i has no effect on logic operations
    for (int op = 2; op < 8; op++) begin
      logic [15:0] y_c0;
      op16 = 3'(op); a16 = 16'hC3A5; b16 = 16'h5A3C; ci16 = 1'b0;
      #1; y_c0 = y16;
      ci16 = 1'b1;
      #1;
      check("R9 cin ignored", {1'b0, y16}, {1'b0, y_c0});
      check("R8 no carry", {16'h0, co16}, 17'h0);
      #1;
    end

    // R11: random vectors on the 16-bit copy against the whole-word model
    for (int i = 0; i < 4000; i++) begin
      a16 = 16'($urandom); b16 = 16'($urandom);
      ci16 = 1'($urandom); op16 = 3'($urandom);
      #1;
      check({req_of(op16), " R11 w16"}, {co16, y16}, model(W16, a16, b16, ci16, op16));
      #1;
    end

    // R11 / R10: exhaustive sweep of the 8-bit copy
    for (int op = 0; op < 8; op++) begin
      for (int c = 0; c < 2; c++) begin
        for (int a = 0; a < 256; a++) begin
          for (int b = 0; b < 256; b++) begin
            op8 = 3'(op); ci8 = 1'(c); a8 = 8'(a); b8 = 8'(b);
            #1;
            check({req_of(op8), " R11 w8"}, {8'h0, co8, y8},
                  model(W8, {8'h0, a8}, {8'h0, b8}, ci8, op8));
          end
        end
      end
    end

    done = 1'b1;
    finish_run();
  end

endmodule